// File: doc/BRIEF.md
# Locked Burst Bus Master

This block is the master side of a shared on-chip bus with request/grant arbitration. A user asserts a one-cycle start command with a byte start address and a word count. The master then requests the bus, and once it holds the grant it streams the words from a valid/ready source into a memory slave as one sequential burst under bus lock. A video frame of 640 by 480 two-byte pixels, 153600 words of 32 bits, fits in the default length field. The burst is not limited in cycles.

The master asserts select, bus lock and all byte enables while it owns the bus. The sequential-address flag tells the slave that more beats follow. It goes low while the final beat is pending. Each accepted word moves the address on by one data word. A retry from the slave gives up the bus and re-arbitrates, then resumes at the first unacknowledged word. An error acknowledge or a timeout ends the transfer at once and leaves a sticky error flag set. When the source has no word ready, the master keeps the bus and presents an empty beat with all byte enables low.

Top module: `burstBusMaster`

## Requirements
- R1: After reset, busReq, busSelect, busLock, busSeqAddr, busBe, busData, srcReady and errFlag are all zero.
- R2: A cmdStart seen while idle with a non-zero cmdLen raises busReq from the next cycle. busReq stays high until busGrant is sampled high. From the cycle after the grant, busReq is low and busSelect, busLock are high. A start with cmdLen of zero is ignored.
- R3: A beat is accepted in a selected cycle when srcValid and xferAck are high and no retry, error acknowledge or timeout is present. In that cycle srcReady is high, busData equals srcData and busAddr equals the start address plus DATA_W/8 times the number of beats accepted before it. Beats are delivered in source order, each exactly once.
- R4: While selected, busSeqAddr is high when more than one beat remains and low when only the final beat remains.
- R5: In the cycle after the final beat is accepted, busSelect, busLock, busSeqAddr, busBe and busData are all zero.
- R6: The master holds busSelect for as long as the burst needs, with no cycle limit, including bursts of over a thousand beats with stalls.
- R7: A retry while selected releases the bus from the next cycle and raises busReq again. After the next grant, the burst resumes at the address of the first unaccepted word, with the remaining count unchanged.
- R8: An errAck or timeout while selected drops every bus output from the next cycle and sets errFlag. errFlag stays set through idle cycles and clears on the next accepted start.
- R9: A selected cycle with srcValid low keeps busSelect high and drives busBe and busData to zero. Any xferAck in that cycle is ignored: srcReady stays low and the address does not advance.
- R10: When errAck or timeout coincides with retry or xferAck, the abort wins. When retry coincides with xferAck, the retry wins and the word is not accepted.
- R11: cmdStart while a command is in progress has no effect on the addresses or the length of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle start command |
| cmdAddr | input | ADDR_W | Byte start address of the burst |
| cmdLen | input | LEN_W | Number of words to move |
| srcValid | input | 1 | Source word available |
| srcData | input | DATA_W | Source word |
| srcReady | output | 1 | Source word accepted this cycle |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Grant from the arbiter |
| busSelect | output | 1 | Master owns the bus |
| busSeqAddr | output | 1 | More sequential beats follow |
| busLock | output | 1 | Bus lock held during the burst |
| busBe | output | DATA_W/8 | Byte enables, all high for a live beat |
| busAddr | output | ADDR_W | Current beat address |
| busData | output | DATA_W | Write data, zero when no live beat |
| xferAck | input | 1 | Slave transfer acknowledge |
| retry | input | 1 | Slave requests a retry |
| errAck | input | 1 | Slave error acknowledge |
| timeout | input | 1 | Bus timeout |
| errFlag | output | 1 | Sticky abort indication |

## Verification
The critical same-cycle collisions involve the slave's acknowledge and its retry or error response. The bench holds xferAck high on every beat. It then raises retry on a chosen beat, errAck on another, and both together on a third. The scoreboard shows which response won. A retried word must come back at the same address after a fresh grant. An aborted word must never appear, and the queue of expected words that is left must match the abort point. Stall cycles with xferAck high are mixed in to show that an acknowledge without data moves nothing.

// File: rtl/bmsPkg.sv
package bmsPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } stateT;

  typedef struct packed {
    logic load;
    logic advance;
  } dpStrobeT;
endpackage

// File: rtl/bmsDatapath.sv
module bmsDatapath
  import bmsPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              beatLive,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              lastBeat
);
  localparam int STEP = DATA_W / 8;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (strobe.load) begin
      curAddr <= cmdAddr;
      remain  <= cmdLen;
    end else if (strobe.advance) begin
      curAddr <= curAddr + ADDR_W'(STEP);
      remain  <= remain - LEN_W'(1);
    end
  end

  assign busAddr  = curAddr;
  assign busData  = beatLive ? srcData : '0;
  assign lastBeat = (remain == LEN_W'(1));

  // R3: the control never takes a beat when no words remain
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (remain != '0));

  // R11: the loaded length cannot change while beats are being taken
  a_r11_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.advance));
endmodule

// File: rtl/bmsControl.sv
module bmsControl
  import bmsPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     lenZero,
  input  logic     busGrant,
  input  logic     srcValid,
  input  logic     xferAck,
  input  logic     retry,
  input  logic     errAck,
  input  logic     timeout,
  input  logic     lastBeat,
  output dpStrobeT strobe,
  output logic     busReq,
  output logic     busSelect,
  output logic     busSeqAddr,
  output logic     busLock,
  output logic     beatLive,
  output logic     srcReady,
  output logic     errFlag
);
  stateT stateQ, stateD;
  logic  inXfer, abortNow, retryNow, beatTaken;

  assign inXfer    = (stateQ == ST_XFER);
  assign abortNow  = inXfer && (errAck || timeout);
  assign retryNow  = inXfer && retry && !abortNow;
  assign beatTaken = inXfer && srcValid && xferAck && !retry && !abortNow;

  always_comb begin
    stateD         = stateQ;
    strobe.load    = (stateQ == ST_IDLE) && cmdStart && !lenZero;
    strobe.advance = beatTaken;
    unique case (stateQ)
      ST_IDLE: if (strobe.load) stateD = ST_REQ;
      ST_REQ:  if (busGrant) stateD = ST_XFER;
      ST_XFER: begin
        if (abortNow)                   stateD = ST_IDLE;
        else if (retryNow)              stateD = ST_REQ;
        else if (beatTaken && lastBeat) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)   errFlag <= 1'b0;
      else if (abortNow) errFlag <= 1'b1;
    end
  end

  assign busReq     = (stateQ == ST_REQ);
  assign busSelect  = inXfer;
  assign busLock    = inXfer;
  assign busSeqAddr = inXfer && !lastBeat;
  assign beatLive   = inXfer && srcValid;
  assign srcReady   = beatTaken;

  // R2: request stays up until the grant arrives
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> busReq);

  // R2: a grant hands over ownership in the next cycle
  a_r2_grant_take: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant) |=> (busSelect && busLock && !busReq));

  // R7: retry gives the bus back and re-requests
  a_r7_retry_rereq: assert property (@(posedge clk) disable iff (!rstN)
    (busSelect && retry && !errAck && !timeout) |=> (busReq && !busSelect));

  // R8 and R10: abort wins and leaves the flag set
  a_r10_abort_wins: assert property (@(posedge clk) disable iff (!rstN)
    (busSelect && (errAck || timeout)) |=> (!busSelect && !busReq && errFlag));

  // R9: a stall never breaks the burst
  a_r9_stall_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (busSelect && !srcValid && !retry && !errAck && !timeout) |=> busSelect);

  // R8: the flag only clears on a new start
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(errFlag)) |-> $past(cmdStart));
endmodule

// File: rtl/burstBusMaster.sv
module burstBusMaster
  import bmsPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdStart,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic [LEN_W-1:0]      cmdLen,
  input  logic                  srcValid,
  input  logic [DATA_W-1:0]     srcData,
  output logic                  srcReady,
  output logic                  busReq,
  input  logic                  busGrant,
  output logic                  busSelect,
  output logic                  busSeqAddr,
  output logic                  busLock,
  output logic [DATA_W/8-1:0]   busBe,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W-1:0]     busData,
  input  logic                  xferAck,
  input  logic                  retry,
  input  logic                  errAck,
  input  logic                  timeout,
  output logic                  errFlag
);
  localparam int BE_W = DATA_W / 8;

  dpStrobeT strobe;
  logic     lastBeat, beatLive, lenZero;

  assign lenZero = (cmdLen == '0);
  assign busBe   = {BE_W{beatLive}};

  bmsControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .lenZero   (lenZero),
    .busGrant  (busGrant),
    .srcValid  (srcValid),
    .xferAck   (xferAck),
    .retry     (retry),
    .errAck    (errAck),
    .timeout   (timeout),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .busReq    (busReq),
    .busSelect (busSelect),
    .busSeqAddr(busSeqAddr),
    .busLock   (busLock),
    .beatLive  (beatLive),
    .srcReady  (srcReady),
    .errFlag   (errFlag)
  );

  bmsDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdAddr (cmdAddr),
    .cmdLen  (cmdLen),
    .beatLive(beatLive),
    .srcData (srcData),
    .busAddr (busAddr),
    .busData (busData),
    .lastBeat(lastBeat)
  );
endmodule

// File: tb/burstBusMaster_bench.sv
`timescale 1ns/1ps
module burstBusMaster_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdStart = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [LW-1:0] cmdLen = '0;
  logic          srcValid = 1'b0;
  logic [DW-1:0] srcData = '0;
  logic          srcReady, busReq, busSelect, busSeqAddr, busLock, errFlag;
  logic          busGrant = 1'b0;
  logic [3:0]    busBe;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;
  logic          xferAck = 1'b0, retry = 1'b0, errAck = 1'b0, timeout = 1'b0;

  int total = 0;
  int bad = 0;

  typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; } itemT;
  itemT expQ[$];

  always #2.5 clk = ~clk;

  burstBusMaster #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_burstBusMaster (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady), .busReq(busReq),
    .busGrant(busGrant), .busSelect(busSelect), .busSeqAddr(busSeqAddr), .busLock(busLock),
    .busBe(busBe), .busAddr(busAddr), .busData(busData), .xferAck(xferAck), .retry(retry),
    .errAck(errAck), .timeout(timeout), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] dataOf(input int base, input int idx);
    return DW'(base * 7 + idx * 13 + 5);
  endfunction

  // driver side of the scoreboard: expected words in order
  task automatic pushExpected(input int base, input int len);
    for (int i = 0; i < len; i++) begin
      itemT it;
      it.addr = AW'(base + 4 * i);
      it.data = dataOf(base, i);
      expQ.push_back(it);
    end
  endtask

  // monitor side: an accepted beat must match the queue head (R3)
  task automatic popCompare();
    itemT it;
    if (expQ.size() == 0) begin
      chk(1'b0, "R3 unexpected beat", 64'(busAddr), 64'hdead);
      return;
    end
    it = expQ.pop_front();
    chk(busAddr == it.addr, "R3 addr", 64'(busAddr), 64'(it.addr));
    chk(busData == it.data, "R3 data", 64'(busData), 64'(it.data));
    chk(srcReady == 1'b1, "R3 srcReady", 64'(srcReady), 64'd1);
  endtask

  task automatic grantPhase();
    repeat (2) begin
      @(negedge clk); busGrant = 1'b0;
      #1;
      chk(busReq == 1'b1, "R2 req held", 64'(busReq), 64'd1);
      chk(busSelect == 1'b0, "R2 no select before grant", 64'(busSelect), 64'd0);
    end
    @(negedge clk); busGrant = 1'b1;
  endtask

  task automatic idleOutputs(input string req, input bit expErr);
    chk(busSelect == 1'b0, req, 64'(busSelect), 64'd0);
    chk(busLock == 1'b0, req, 64'(busLock), 64'd0);
    chk(busSeqAddr == 1'b0, req, 64'(busSeqAddr), 64'd0);
    chk(busBe == 4'h0, req, 64'(busBe), 64'd0);
    chk(busData == '0, req, 64'(busData), 64'd0);
    chk(busReq == 1'b0, req, 64'(busReq), 64'd0);
    chk(errFlag == expErr, "R8 errFlag", 64'(errFlag), 64'(expErr));
  endtask

  task automatic doBurst(input int base, input int len, input int stallEvery,
                         input int retryAt, input int errAt, input bit useTimeout);
    int idx = 0;
    int c = 0;
    bit retried = 1'b0;
    bit aborted = 1'b0;
    pushExpected(base, len);
    @(negedge clk);
    cmdStart = 1'b1; cmdAddr = AW'(base); cmdLen = LW'(len);
    @(negedge clk);
    cmdStart = 1'b0;
    #1;
    chk(busReq == 1'b1, "R2 req after start", 64'(busReq), 64'd1);
    chk(errFlag == 1'b0, "R8 cleared by start", 64'(errFlag), 64'd0);
    grantPhase();
    while (idx < len && !aborted && c < 20000) begin
      bit errNow, retryNow;
      @(negedge clk);
      busGrant = 1'b0;
      cmdStart = (c == 3);               // R11 start while busy
      cmdAddr  = 32'hBAD0_0000;
      cmdLen   = LW'(2);
      srcValid = (stallEvery == 0) || ((c % stallEvery) != 1);
      srcData  = dataOf(base, idx);
      xferAck  = 1'b1;
      errNow   = (idx == errAt) && srcValid;
      retryNow = (idx == retryAt) && srcValid && !retried;
      retry    = retryNow;
      errAck   = errNow && !useTimeout;
      timeout  = errNow && useTimeout;
      #1;
      chk(busSelect == 1'b1, "R6 select held", 64'(busSelect), 64'd1);
      chk(busLock == 1'b1, "R6 lock held", 64'(busLock), 64'd1);
      chk(busReq == 1'b0, "R2 req dropped", 64'(busReq), 64'd0);
      chk(busSeqAddr == ((len - idx) > 1), "R4 seqAddr", 64'(busSeqAddr), 64'((len - idx) > 1));
      if (!srcValid) begin
        chk(busBe == 4'h0, "R9 stall be", 64'(busBe), 64'd0);
        chk(busData == '0, "R9 stall data", 64'(busData), 64'd0);
        chk(srcReady == 1'b0, "R9 ack ignored", 64'(srcReady), 64'd0);
      end else begin
        chk(busBe == 4'hF, "R3 be", 64'(busBe), 64'hF);
        if (errNow) begin
          chk(srcReady == 1'b0, "R10 abort beats ack", 64'(srcReady), 64'd0);
          aborted = 1'b1;
        end else if (retryNow) begin
          chk(srcReady == 1'b0, "R10 retry beats ack", 64'(srcReady), 64'd0);
          retried = 1'b1;
          @(negedge clk);
          cmdStart = 1'b0; retry = 1'b0; xferAck = 1'b0; srcValid = 1'b0;
          #1;
          chk(busSelect == 1'b0, "R7 released", 64'(busSelect), 64'd0);
          chk(busReq == 1'b1, "R7 re-request", 64'(busReq), 64'd1);
          grantPhase();
        end else begin
          popCompare();
          idx++;
        end
      end
      c++;
    end
    @(negedge clk);
    cmdStart = 1'b0; srcValid = 1'b0; xferAck = 1'b0;
    retry = 1'b0; errAck = 1'b0; timeout = 1'b0;
    #1;
    idleOutputs(aborted ? "R8 abort idle" : "R5 end idle", aborted);
    if (aborted) begin
      chk(expQ.size() == len - errAt, "R8 words left", 64'(expQ.size()), 64'(len - errAt));
      expQ.delete();
    end else begin
      chk(expQ.size() == 0, "R3 all delivered", 64'(expQ.size()), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    idleOutputs("R1 reset", 1'b0);
    chk(srcReady == 1'b0, "R1 srcReady", 64'(srcReady), 64'd0);

    // R2 zero length ignored
    @(negedge clk); cmdStart = 1'b1; cmdLen = '0; cmdAddr = 32'h100;
    @(negedge clk); cmdStart = 1'b0;
    #1;
    chk(busReq == 1'b0, "R2 zero length ignored", 64'(busReq), 64'd0);

    doBurst(32'h1000, 1, 0, -1, -1, 1'b0);    // R4 single beat
    doBurst(32'h2000, 8, 3, -1, -1, 1'b0);    // R9 stalls
    doBurst(32'h3000, 10, 0, 4, -1, 1'b0);    // R7 retry
    doBurst(32'h4000, 10, 4, -1, 6, 1'b0);    // R8 error ack
    repeat (5) begin
      @(negedge clk); #1;
      chk(errFlag == 1'b1, "R8 sticky", 64'(errFlag), 64'd1);
    end
    doBurst(32'h5000, 6, 0, -1, 2, 1'b1);     // R8 timeout
    doBurst(32'h6000, 4, 0, -1, -1, 1'b0);    // R8 flag cleared by start
    doBurst(32'h7000, 6, 0, 3, 3, 1'b0);      // R10 error with retry
    doBurst(32'h10000, 1200, 5, 700, -1, 1'b0); // R6 long burst

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule